// File: doc/BRIEF.md
# Software-Triggerable Reset Controller

This block turns the level on a shared, active-low, open-drain reset pin into the core's internal reset. Anything outside the chip may pull the pin low; the CPU may also pull it low itself by clearing an internal pin-control bit, which turns the pin's pull-down transistor on. The block never drives the pin high. It only switches its pull-down on or off. The pin level arrives through a two-flop synchroniser. A saturating counter measures how long the synchronised level has stayed low.

Once a reset is taken, the control bit returns to 1 and releases the pin. A software reset therefore ends without further software action. After the synchronised pin reads high again, the core stays in reset for a stabilisation wait of `WAIT_CYC` clocks (16384 by default). In the cycle the core reset falls, the block raises a one-cycle request to fetch the reset vector, and the core then runs in its normal high-speed clock mode.

The parameter `FILTER_SHORT` selects how short low pulses are treated. With 0, the default, any synchronised low takes a reset. With 1, the pin must read low for `MIN_LOW` consecutive synchronised cycles first.

Top module: `swrst_ctrl`

## Requirements
- R1: While `rst` is high, `core_rst_o` is 1, `pin_pd_o` is 0 and `vec_req_o` is 0. If the pin is high when `rst` falls, `vec_req_o` pulses on the (1+WAIT_CYC)-th rising edge after the release.
- R2: A pin low for `MIN_LOW` consecutive clocks always causes a reset, in both variants. `core_rst_o` is 1 no later than the (2+MIN_LOW)-th edge after the first low sample.
- R3: With `FILTER_SHORT`=0, a pin low for even one clock sets `core_rst_o` on the third rising edge after the first edge that samples it low.
- R4: With `FILTER_SHORT`=1, a low pulse shorter than `MIN_LOW` clocks leaves `core_rst_o` at 0.
- R5: `core_rst_o` stays 1 while the synchronised pin is low. After the pin is released, it stays 1 until the rising edge WAIT_CYC+3 after the first edge that samples the pin high. A low during the wait restarts that count from the next release.
- R6: `vec_req_o` is a one-cycle pulse. It occurs exactly in the cycle in which `core_rst_o` falls, and only then.
- R7: A write of 0 (`ctl_wr`=1, `ctl_wdata`=0) while the core is running sets `pin_pd_o` to 1 after the next edge. This pulls the pin low and starts a software reset.
- R8: Entering reset sets the control bit back to 1, so `pin_pd_o` is 0 whenever `core_rst_o` is 1. After a write of 0, the pin is released on the third edge following the write edge, and the reset vector follows without further writes.
- R9: Writes made while `core_rst_o` is 1 are ignored. A write of 1 leaves `pin_pd_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high initialisation of the controller |
| pin_i | input | 1 | Sampled level of the reset pin (0 = low), asynchronous |
| ctl_wr | input | 1 | CPU write strobe for the pin-control bit |
| ctl_wdata | input | 1 | Value written to the pin-control bit (0 pulls the pin low) |
| pin_pd_o | output | 1 | Enable for the open-drain pull-down on the pin |
| core_rst_o | output | 1 | Reset to the core, active high |
| vec_req_o | output | 1 | One-cycle request to start reset-vector processing |

## Verification
The assertions take for granted that `rst` is high at time zero. They also assume that `ctl_wr` and `ctl_wdata` are synchronous to `clk`, while `pin_i` may change at any time. The bench changes every input only on the falling clock edge. It models the pin as a wired-AND of an external pull-down and the block's own `pin_pd_o`, so the pin can only be pulled low or released, never driven high. Two instances run side by side, one per `FILTER_SHORT` setting. The short-pulse cases therefore sit directly next to each other.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } rst_state_e;
endpackage

// File: rtl/swrst_sync.sv
module swrst_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swrst_lowcnt.sv
module swrst_lowcnt #(
  parameter int MIN_LOW      = 4,
  parameter bit FILTER_SHORT = 1'b0,
  localparam int CW          = $clog2(MIN_LOW + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_s,
  output logic trig_o
);
  logic [CW-1:0] low_cnt;

  // saturating count of consecutive low samples seen before this cycle
  always_ff @(posedge clk) begin
    if (rst || lvl_s)                   low_cnt <= '0;
    else if (low_cnt != CW'(MIN_LOW))   low_cnt <= low_cnt + 1'b1;
  end

  generate
    if (FILTER_SHORT) begin : g_filter
      assign trig_o = !lvl_s && (low_cnt >= CW'(MIN_LOW - 1));
    end else begin : g_direct
      assign trig_o = !lvl_s;
    end
  endgenerate

  a_r2_cnt_clears: assert property (@(posedge clk) disable iff (rst)
    lvl_s |=> (low_cnt == '0));

  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= CW'(MIN_LOW));
endmodule

// File: rtl/swrst_seq.sv
module swrst_seq #(
  parameter int WAIT_CYC = 16384,
  localparam int WW      = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_s,
  input  logic trig,
  input  logic wr,
  input  logic wdata,
  output logic core_rst_o,
  output logic vec_o,
  output logic ctl_o
);
  import swrst_pkg::*;

  rst_state_e st_q, st_d;
  logic [WW-1:0] wcnt_q;
  logic core_q, vec_q, ctl_q;
  logic wait_done;

  assign wait_done = (wcnt_q == WW'(WAIT_CYC - 1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:  if (trig) st_d = ST_HOLD;
      ST_HOLD: if (lvl_s) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!lvl_s)         st_d = ST_HOLD;
        else if (wait_done) st_d = ST_RUN;
      end
      default: st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_HOLD;
      wcnt_q <= '0;
      core_q <= 1'b1;
      vec_q  <= 1'b0;
      ctl_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      wcnt_q <= (st_q == ST_WAIT && st_d == ST_WAIT) ? wcnt_q + 1'b1 : '0;
      core_q <= (st_d != ST_RUN);
      vec_q  <= (st_q == ST_WAIT) && (st_d == ST_RUN);
      if (st_d != ST_RUN)                      ctl_q <= 1'b1;
      else if (wr && st_q == ST_RUN)           ctl_q <= wdata;
    end
  end

  assign core_rst_o = core_q;
  assign vec_o      = vec_q;
  assign ctl_o      = ctl_q;

  a_r6_vec_single: assert property (@(posedge clk) disable iff (rst)
    vec_q |=> !vec_q);

  a_r6_vec_at_release: assert property (@(posedge clk) disable iff (rst)
    vec_q |-> (!core_q && $past(core_q)));

  a_r8_pin_free_in_reset: assert property (@(posedge clk) disable iff (rst)
    core_q |-> ctl_q);

  a_r5_wait_bounded: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> (wcnt_q < WW'(WAIT_CYC)));

  a_r5_low_keeps_reset: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN && !lvl_s) |=> core_q);
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_LOW      = 4,
  parameter bit FILTER_SHORT = 1'b0,
  parameter int WAIT_CYC     = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic ctl_wr,
  input  logic ctl_wdata,
  output logic pin_pd_o,
  output logic core_rst_o,
  output logic vec_req_o
);
  logic lvl_s, trig_w, ctl_w;

  swrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst(rst), .d(pin_i), .q(lvl_s)
  );

  swrst_lowcnt #(.MIN_LOW(MIN_LOW), .FILTER_SHORT(FILTER_SHORT)) lowcnt_i (
    .clk(clk), .rst(rst), .lvl_s(lvl_s), .trig_o(trig_w)
  );

  swrst_seq #(.WAIT_CYC(WAIT_CYC)) seq_i (
    .clk(clk), .rst(rst), .lvl_s(lvl_s), .trig(trig_w),
    .wr(ctl_wr), .wdata(ctl_wdata),
    .core_rst_o(core_rst_o), .vec_o(vec_req_o), .ctl_o(ctl_w)
  );

  // open-drain: only a pull-down enable leaves the block
  assign pin_pd_o = ~ctl_w;

  a_r6_fall_has_vec: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> vec_req_o);

  a_r7_write_pulls_low: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_wdata && !core_rst_o && !trig_w) |=> pin_pd_o);

  a_r9_write_in_reset_ignored: assert property (@(posedge clk) disable iff (rst)
    (core_rst_o && !pin_pd_o) |=> !pin_pd_o);
endmodule

// File: tb/swrst_ctrl_tb_top.sv
module swrst_ctrl_tb_top;
  localparam int W  = 20;
  localparam int ML = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_d = 1'b0, ext_f = 1'b0;
  logic wr = 1'b0, wd = 1'b1;
  logic zero = 1'b0, one = 1'b1;
  logic pd_d, core_d, vec_d, pd_f, core_f, vec_f;
  logic pin_d, pin_f;
  int cyc = 0;
  int total = 0, bad = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // wired-AND open-drain pin models
  assign pin_d = ~(ext_d | pd_d);
  assign pin_f = ~(ext_f | pd_f);

  swrst_ctrl #(.MIN_LOW(ML), .FILTER_SHORT(1'b0), .WAIT_CYC(W)) dut_i (
    .clk(clk), .rst(rst), .pin_i(pin_d), .ctl_wr(wr), .ctl_wdata(wd),
    .pin_pd_o(pd_d), .core_rst_o(core_d), .vec_req_o(vec_d)
  );

  swrst_ctrl #(.MIN_LOW(ML), .FILTER_SHORT(1'b1), .WAIT_CYC(W)) dut_f (
    .clk(clk), .rst(rst), .pin_i(pin_f), .ctl_wr(zero), .ctl_wdata(one),
    .pin_pd_o(pd_f), .core_rst_o(core_f), .vec_req_o(vec_f)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() > 0 && !done) step(1);
    step(2);
  endtask

  // monitor: every vector request must match a queued expected cycle (R6)
  always @(negedge clk) begin
    if (!rst && vec_d) begin
      if (exp_q.size() == 0) chk("R6 unexpected vector request", 1, 0);
      else chk("R6 vector request cycle", cyc, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(4);
    // R1 reset state
    chk("R1 core reset in init", core_d, 1);
    chk("R1 no pull-down in init", pd_d, 0);
    chk("R1 no vector in init", vec_d, 0);
    chk("R1 filter core reset in init", core_f, 1);
    rst = 1'b0;
    exp_q.push_back(cyc + 1 + W);
    step(W);
    chk("R1 still waiting", core_d, 1);
    step(1);
    chk("R1 filter vector after init", vec_f, 1);
    chk("R1 filter core released", core_f, 0);
    drain();

    // R3 / R4: three-cycle low pulse on both
    ext_d = 1'b1; ext_f = 1'b1;
    step(3);
    chk("R3 short low resets direct variant", core_d, 1);
    chk("R8 pin released in reset", pd_d, 0);
    ext_d = 1'b0; ext_f = 1'b0;
    exp_q.push_back(cyc + 3 + W);
    step(4);
    chk("R4 short low ignored by filter variant", core_f, 0);
    drain();
    chk("R4 filter still running", core_f, 0);

    // R3 one-cycle glitch
    ext_d = 1'b1;
    step(1);
    ext_d = 1'b0;
    exp_q.push_back(cyc + 3 + W);
    step(2);
    chk("R3 one-cycle glitch resets", core_d, 1);
    drain();

    // R2: MIN_LOW low cycles reset both variants
    ext_d = 1'b1; ext_f = 1'b1;
    step(3);
    chk("R2 direct variant reset", core_d, 1);
    step(1);
    ext_d = 1'b0; ext_f = 1'b0;
    exp_q.push_back(cyc + 3 + W);
    step(2);
    chk("R2 filter variant reset after MIN_LOW", core_f, 1);
    step(W);
    chk("R5 filter still in wait", core_f, 1);
    chk("R6 filter no early vector", vec_f, 0);
    step(1);
    chk("R6 filter vector", vec_f, 1);
    chk("R6 filter core released", core_f, 0);
    step(1);
    chk("R6 filter vector single cycle", vec_f, 0);
    drain();

    // R5: low during wait restarts the wait
    ext_d = 1'b1;
    step(4);
    ext_d = 1'b0;
    step(6);
    chk("R5 in wait", core_d, 1);
    ext_d = 1'b1;
    step(3);
    ext_d = 1'b0;
    exp_q.push_back(cyc + 3 + W);
    step(W + 2);
    chk("R5 wait restarted", core_d, 1);
    chk("R5 no vector before wait end", vec_d, 0);
    step(1);
    chk("R6 vector at release", vec_d, 1);
    chk("R5 core released", core_d, 0);
    step(1);
    chk("R6 vector single cycle", vec_d, 0);
    drain();

    // R7 / R8: software reset
    wr = 1'b1; wd = 1'b0;
    exp_q.push_back(cyc + 7 + W);
    step(1);
    wr = 1'b0; wd = 1'b1;
    chk("R7 write 0 pulls pin", pd_d, 1);
    step(2);
    chk("R7 pin still pulled", pd_d, 1);
    step(1);
    chk("R8 software reset taken", core_d, 1);
    chk("R8 pin released by reset", pd_d, 0);
    drain();
    chk("R8 core running after software reset", core_d, 0);

    // R9: writes in reset ignored, write 1 keeps pin free
    ext_d = 1'b1;
    step(3);
    wr = 1'b1; wd = 1'b0;
    step(1);
    wr = 1'b0; wd = 1'b1;
    chk("R9 write in reset ignored", pd_d, 0);
    ext_d = 1'b0;
    exp_q.push_back(cyc + 3 + W);
    drain();
    chk("R9 pin free after reset", pd_d, 0);
    wr = 1'b1; wd = 1'b1;
    step(1);
    wr = 1'b0;
    chk("R9 write 1 keeps pin free", pd_d, 0);
    step(3);
    chk("R9 no reset after write 1", core_d, 0);

    chk("R6 all expected vectors seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule